// File: doc/BRIEF.md
# Quadword Memory-to-Stream DMA Channel

This block is one DMA channel that moves a run of 128-bit quadwords from memory into a streaming sink. Software sets a start address and a quadword count through a narrow write-only register port, then sets the start bit. The channel reads one quadword at a time over a request/valid memory port and passes each one to a valid/ready/last output stream.

When the final quadword has been accepted downstream, the channel returns to idle on its own. It then pulses a completion interrupt and emits exactly one typed trace event. The event records the start address and the count of the finished transfer. While a transfer runs, the channel ignores every register write, so the programmed values stay fixed until the channel is idle again.

Top module: `qdma_channel`

## Requirements
- R1: A write at offset 0x10 loads the start address (low ADDR_W bits of the data). A write at offset 0x20 loads the quadword count (low CNT_W bits). Both take effect only while the channel is idle, and both keep their values across transfers.
- R2: A write at offset 0x00 with data bit 0 set starts a transfer from the current address and count. A write at 0x00 with bit 0 clear starts nothing.
- R3: A transfer of N quadwords issues exactly N memory reads. The first read is at the start address, and each following read is 16 bytes higher, wrapping modulo 2^ADDR_W.
- R4: At most one memory read is outstanding. No new read is issued while a returned quadword waits to be accepted downstream.
- R5: Output beats carry the read quadwords in read order. ep_last is high on the final beat only.
- R6: While ep_valid is high and ep_ready is low, ep_valid stays high and ep_data and ep_last stay unchanged.
- R7: irq_done is high for exactly the one cycle after the final beat is accepted. The channel is then idle and accepts a new start.
- R8: Each completed transfer produces one trace event in the same cycle as irq_done. The event has ev_valid high, ev_kind = 1, ev_addr equal to the start address and ev_count equal to the count. No other cycle has ev_valid high.
- R9: A start with a count of 0 issues no reads and no beats. It raises irq_done and the trace event in the cycle after the start write.
- R10: Any register write that arrives while a transfer is in progress, including a start, has no effect.
- R11: After reset, mem_rd_en, ep_valid, ep_last, irq_done and ev_valid are low, and the address and count registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_offset | input | OFF_W | Register byte offset |
| cfg_wr_data | input | REG_W | Register write data |
| mem_rd_en | output | 1 | Memory read request, one cycle per quadword |
| mem_rd_addr | output | ADDR_W | Byte address of the requested quadword |
| mem_rd_data | input | DATA_W | Returned quadword |
| mem_rd_valid | input | 1 | Returned quadword is valid |
| ep_valid | output | 1 | Output beat valid |
| ep_data | output | DATA_W | Output beat data |
| ep_last | output | 1 | Final beat of the transfer |
| ep_ready | input | 1 | Sink accepts the beat |
| irq_done | output | 1 | One-cycle completion pulse |
| ev_valid | output | 1 | Trace event valid |
| ev_kind | output | 4 | Trace event code, 1 = transfer done |
| ev_addr | output | ADDR_W | Start address of the finished transfer |
| ev_count | output | CNT_W | Quadword count of the finished transfer |

## Verification
The bench builds the channel with ADDR_W = 16 and CNT_W = 6, keeping the 128-bit data width and the 8-bit offsets. The narrow address lets a short transfer starting at 0xFFE0 run past the top of the address space, so the bench can check the modulo wrap of the read address. The small count keeps every transfer short. This leaves room in the run for several read latencies and ready patterns (always ready, alternating, pseudo-random), for writes that arrive while busy, and for zero-count starts.

// File: rtl/qdma_pkg.sv
// Shared constants and types for the quadword DMA channel.
// Assumes 8-bit register offsets; the offsets are fixed by the software view.
package qdma_pkg;
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_ADDR  = 8'h10;
    localparam logic [7:0] OFF_COUNT = 8'h20;
    localparam int         START_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SEND
    } qdma_state_e;

    typedef enum logic [3:0] {
        EVK_NONE      = 4'd0,
        EVK_XFER_DONE = 4'd1
    } qdma_evkind_e;
endpackage

// File: rtl/qdma_regs.sv
// Register decode: holds the start address and the quadword count, and
// produces a one-cycle launch strobe when the start bit is written.
// Assumes ADDR_W and CNT_W are no wider than REG_W. All writes are dropped
// while busy is high.
module qdma_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int OFF_W  = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              busy,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  qw_count,
    output logic              launch
);
    import qdma_pkg::*;

    logic accept;
    assign accept = wr_en && !busy;

    // Load the address and count registers from idle-time writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            qw_count  <= '0;
        end else if (accept) begin
            if (offset == OFF_W'(OFF_ADDR))
                base_addr <= wr_data[ADDR_W-1:0];
            if (offset == OFF_W'(OFF_COUNT))
                qw_count <= wr_data[CNT_W-1:0];
        end
    end

    // Start strobe: an idle write to the control offset with the start bit set.
    always_comb begin
        launch = accept && (offset == OFF_W'(OFF_CTRL)) && wr_data[START_BIT];
    end
endmodule

// File: rtl/qdma_mover.sv
// Read sequencer and output stage: one read per quadword, holds the returned
// quadword on the stream until accepted, then moves to the next address.
// Assumes the memory answers each read with exactly one mem_rd_valid pulse.
module qdma_mover #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  qw_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              ep_valid,
    output logic [DATA_W-1:0] ep_data,
    output logic              ep_last,
    input  logic              ep_ready,
    output logic              busy,
    output logic              done
);
    import qdma_pkg::*;

    localparam int QW_BYTES = DATA_W / 8;

    qdma_state_e       state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  left;
    logic [DATA_W-1:0] held;
    logic              final_beat;

    assign final_beat = (left == CNT_W'(1));

    // Sequence requests, captures and beat hand-offs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            left     <= '0;
            held     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch && qw_count != '0) begin
                        cur_addr <= base_addr;
                        left     <= qw_count;
                        state    <= ST_REQ;
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        held  <= mem_rd_data;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (ep_ready) begin
                        left     <= left - CNT_W'(1);
                        cur_addr <= cur_addr + ADDR_W'(QW_BYTES);
                        state    <= final_beat ? ST_IDLE : ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port and status outputs decoded from the state.
    always_comb begin
        mem_rd_en   = (state == ST_REQ);
        mem_rd_addr = cur_addr;
        ep_valid    = (state == ST_SEND);
        ep_data     = held;
        ep_last     = (state == ST_SEND) && final_beat;
        busy        = (state != ST_IDLE);
        done        = ((state == ST_SEND) && ep_ready && final_beat)
                   || (state == ST_IDLE && launch && qw_count == '0);
    end
endmodule

// File: rtl/qdma_notify.sv
// Completion reporting: registers the done strobe into a one-cycle interrupt
// and a trace event that carries the programmed address and count.
// Assumes the address and count are stable in the done cycle.
module qdma_notify #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  qw_count,
    output logic              irq_done,
    output logic              ev_valid,
    output logic [3:0]        ev_kind,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [CNT_W-1:0]  ev_count
);
    import qdma_pkg::*;

    // Register the pulse and capture the event payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done <= 1'b0;
            ev_valid <= 1'b0;
            ev_addr  <= '0;
            ev_count <= '0;
        end else begin
            irq_done <= done;
            ev_valid <= done;
            if (done) begin
                ev_addr  <= base_addr;
                ev_count <= qw_count;
            end
        end
    end

    // Event code is only non-zero alongside a valid event.
    always_comb begin
        ev_kind = ev_valid ? 4'(EVK_XFER_DONE) : 4'(EVK_NONE);
    end
endmodule

// File: rtl/qdma_channel.sv
// Top of the quadword DMA channel: register decode, read/stream mover and
// completion reporting. Assumes a single memory slave and a single sink.
module qdma_channel #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 128,
    parameter int OFF_W  = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              ep_valid,
    output logic [DATA_W-1:0] ep_data,
    output logic              ep_last,
    input  logic              ep_ready,
    output logic              irq_done,
    output logic              ev_valid,
    output logic [3:0]        ev_kind,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [CNT_W-1:0]  ev_count
);
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  qw_count;
    logic              launch;
    logic              busy;
    logic              done;

    qdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .offset(cfg_offset),
        .wr_data(cfg_wr_data), .busy(busy), .base_addr(base_addr),
        .qw_count(qw_count), .launch(launch)
    );

    qdma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .launch(launch), .base_addr(base_addr),
        .qw_count(qw_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .ep_valid(ep_valid), .ep_data(ep_data), .ep_last(ep_last),
        .ep_ready(ep_ready), .busy(busy), .done(done)
    );

    qdma_notify #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_notify (
        .clk(clk), .rst_n(rst_n), .done(done), .base_addr(base_addr),
        .qw_count(qw_count), .irq_done(irq_done), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_count(ev_count)
    );
endmodule

// File: rtl/qdma_channel_checks.sv
// Port-level protocol checks for the quadword DMA channel, bound to the top.
module qdma_channel_checks #(
    parameter int DATA_W = 128,
    parameter int OFF_W  = 8,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [OFF_W-1:0]  cfg_offset,
    input logic [REG_W-1:0]  cfg_wr_data,
    input logic              mem_rd_en,
    input logic              ep_valid,
    input logic [DATA_W-1:0] ep_data,
    input logic              ep_last,
    input logic              ep_ready,
    input logic              irq_done,
    input logic              ev_valid,
    input logic [3:0]        ev_kind
);
    // R6: a stalled beat keeps its contents
    p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && !ep_ready) |=> (ep_valid && $stable(ep_data) && $stable(ep_last)));

    // R4: a request is never followed directly by another request
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R4: no read while a quadword is held on the stream
    p_no_read_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ep_valid |-> !mem_rd_en);

    // R5: the stream goes quiet after the last beat is taken
    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && ep_ready && ep_last) |=> !ep_valid);

    // R7: the interrupt follows a final accept or a start write
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> ($past(ep_valid && ep_ready && ep_last)
                      || $past(cfg_wr_en && cfg_offset == '0 && cfg_wr_data[0])));

    // R8: a valid trace event carries the done code
    p_event_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_kind == 4'd1));
endmodule

bind qdma_channel qdma_channel_checks #(.DATA_W(DATA_W), .OFF_W(OFF_W), .REG_W(REG_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset),
    .cfg_wr_data(cfg_wr_data), .mem_rd_en(mem_rd_en), .ep_valid(ep_valid),
    .ep_data(ep_data), .ep_last(ep_last), .ep_ready(ep_ready),
    .irq_done(irq_done), .ev_valid(ev_valid), .ev_kind(ev_kind)
);

// File: tb/qdma_channel_bench.sv
`timescale 1ns/1ps
module qdma_channel_bench;
    localparam int AW = 16;
    localparam int CW = 6;

    logic          clk;
    logic          rst_n;
    logic          cfg_wr_en;
    logic [7:0]    cfg_offset;
    logic [31:0]   cfg_wr_data;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [127:0]  mem_rd_data;
    logic          mem_rd_valid;
    logic          ep_valid;
    logic [127:0]  ep_data;
    logic          ep_last;
    logic          ep_ready;
    logic          irq_done;
    logic          ev_valid;
    logic [3:0]    ev_kind;
    logic [AW-1:0] ev_addr;
    logic [CW-1:0] ev_count;

    qdma_channel #(.ADDR_W(AW), .CNT_W(CW)) u_qdma_channel (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset),
        .cfg_wr_data(cfg_wr_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .ep_valid(ep_valid), .ep_data(ep_data), .ep_last(ep_last),
        .ep_ready(ep_ready), .irq_done(irq_done), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_count(ev_count)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mem_word(input logic [AW-1:0] a);
        logic [31:0] b;
        b = {16'h0, a};
        return {b ^ 32'hA5A5_0000, ~b, b + 32'h1111_0000, b ^ 32'h0000_5A5A};
    endfunction

    int unsigned seed = 32'h1234_5678;
    int rdy_mode = 0;

    // Memory responder: one reply per request after 1..4 cycles.
    initial begin
        int pend;
        logic [AW-1:0] pend_addr;
        pend = -1;
        pend_addr = '0;
        mem_rd_valid = 1'b0;
        mem_rd_data = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data = mem_word(pend_addr);
                    pend = -1;
                end
            end
            if (mem_rd_en && rst_n) begin
                seed = seed * 1103515245 + 12345;
                pend = 1 + int'((seed >> 16) % 4);
                pend_addr = mem_rd_addr;
            end
        end
    end

    // Sink ready pattern.
    initial begin
        ep_ready = 1'b0;
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: ep_ready = 1'b1;
                1: ep_ready = ~ep_ready;
                2: begin
                    seed = seed * 1103515245 + 12345;
                    ep_ready = seed[20] & seed[21];
                end
                default: ep_ready = 1'b0;
            endcase
        end
    end

    // Behavioural reference model, compared every cycle before the edge.
    bit m_busy = 0;
    logic [AW-1:0] m_addr = '0;
    logic [CW-1:0] m_count = '0;
    logic [AW-1:0] exp_rd[$];
    logic [127:0]  exp_beat[$];
    logic [AW-1:0] rd_log[$];
    int outstanding = 0;
    bit held_valid = 0;
    logic [127:0] held_data = '0;
    bit irq_due = 0;
    logic [AW-1:0] ev_exp_addr = '0;
    logic [CW-1:0] ev_exp_count = '0;
    int dones = 0;
    int beats = 0;

    initial begin
        forever begin
            bit busy_now;
            bit irq_next;
            @(negedge clk);
            #5;
            if (!rst_n) continue;
            busy_now = m_busy;
            irq_next = 0;
            if (irq_due) begin
                chk(irq_done === 1'b1, "R7", "irq pulse", irq_done, 1);
                chk(ev_valid === 1'b1 && ev_kind == 4'd1, "R8", "event valid/kind",
                    {ev_valid, ev_kind}, {1'b1, 4'd1});
                chk(ev_addr == ev_exp_addr && ev_count == ev_exp_count, "R8", "event payload",
                    {ev_addr, 2'b0, ev_count}, {ev_exp_addr, 2'b0, ev_exp_count});
                dones++;
            end else begin
                chk(irq_done === 1'b0 && ev_valid === 1'b0, "R7", "no spurious irq/event",
                    {irq_done, ev_valid}, 0);
            end
            irq_due = 0;
            if (held_valid)
                chk(ep_valid === 1'b1 && ep_data == held_data, "R6", "stalled beat held",
                    ep_data, held_data);
            if (mem_rd_valid) outstanding = 0;
            if (mem_rd_en) begin
                rd_log.push_back(mem_rd_addr);
                chk(exp_rd.size() > 0, "R3", "unexpected read", mem_rd_addr, 0);
                if (exp_rd.size() > 0) begin
                    chk(mem_rd_addr == exp_rd[0], "R3", "read address", mem_rd_addr, exp_rd[0]);
                    void'(exp_rd.pop_front());
                end
                chk(outstanding == 0 && !ep_valid, "R4", "read while busy",
                    {outstanding[0], ep_valid}, 0);
                outstanding = 1;
            end
            if (ep_valid) begin
                chk(exp_beat.size() > 0, "R5", "unexpected beat", ep_data, 0);
                if (ep_ready && exp_beat.size() > 0) begin
                    chk(ep_data == exp_beat[0], "R5", "beat data", ep_data, exp_beat[0]);
                    chk(ep_last == (exp_beat.size() == 1), "R5", "last flag",
                        ep_last, exp_beat.size() == 1);
                    void'(exp_beat.pop_front());
                    beats++;
                    held_valid = 0;
                    if (exp_beat.size() == 0) begin
                        irq_next = 1;
                        m_busy = 0;
                    end
                end else if (!ep_ready) begin
                    held_valid = 1;
                    held_data = ep_data;
                end
            end else begin
                held_valid = 0;
            end
            if (cfg_wr_en && !busy_now) begin
                if (cfg_offset == 8'h10) m_addr = cfg_wr_data[AW-1:0];
                if (cfg_offset == 8'h20) m_count = cfg_wr_data[CW-1:0];
                if (cfg_offset == 8'h00 && cfg_wr_data[0]) begin
                    ev_exp_addr = m_addr;
                    ev_exp_count = m_count;
                    if (m_count == 0) begin
                        irq_next = 1;
                    end else begin
                        m_busy = 1;
                        for (int i = 0; i < int'(m_count); i++) begin
                            logic [AW-1:0] a;
                            a = m_addr + AW'(16 * i);
                            exp_rd.push_back(a);
                            exp_beat.push_back(mem_word(a));
                        end
                    end
                end
            end
            irq_due = irq_next;
        end
    end

    task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_offset = off;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_offset = '0;
        cfg_wr_data = '0;
    endtask

    task automatic wait_done();
        int start;
        start = dones;
        while (dones == start) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_xfer(input logic [15:0] a, input int n);
        cfg_write(8'h10, {16'h0, a});
        cfg_write(8'h20, n);
        cfg_write(8'h00, 32'h1);
        wait_done();
    endtask

    initial begin
        int r0, b0, d0;
        cfg_wr_en = 1'b0;
        cfg_offset = '0;
        cfg_wr_data = '0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        chk({mem_rd_en, ep_valid, ep_last, irq_done, ev_valid} == 5'b0, "R11", "reset outputs",
            {mem_rd_en, ep_valid, ep_last, irq_done, ev_valid}, 0);

        // R9 from reset: registers are zero, so a bare start is a zero-count transfer
        d0 = dones; r0 = rd_log.size();
        cfg_write(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        chk(dones == d0 + 1 && rd_log.size() == r0, "R9", "zero count after reset",
            {dones, rd_log.size()}, {d0 + 1, r0});

        // R1 R3 R5 R7 R8: basic two-quadword move with ready always high
        rdy_mode = 0;
        run_xfer(16'h0100, 2);
        chk(rd_log.size() == r0 + 2, "R3", "two reads", rd_log.size(), r0 + 2);

        // R5 R6: longer transfer, alternating ready
        rdy_mode = 1;
        run_xfer(16'h2000, 5);

        // R10: writes during a busy transfer are ignored
        rdy_mode = 2;
        r0 = rd_log.size(); b0 = beats;
        cfg_write(8'h10, 32'h3000);
        cfg_write(8'h20, 4);
        cfg_write(8'h00, 32'h1);
        cfg_write(8'h10, 32'h9990);
        cfg_write(8'h20, 7);
        cfg_write(8'h00, 32'h1);
        wait_done();
        chk(beats == b0 + 4, "R10", "busy start ignored", beats, b0 + 4);
        r0 = rd_log.size();
        cfg_write(8'h00, 32'h1);
        wait_done();
        chk(rd_log.size() == r0 + 4 && rd_log[r0] == 16'h3000, "R10", "registers unchanged",
            {rd_log.size(), rd_log[r0]}, {r0 + 4, 16'h3000});

        // R2: control write with bit 0 clear starts nothing
        r0 = rd_log.size(); d0 = dones;
        cfg_write(8'h00, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        chk(rd_log.size() == r0 && dones == d0, "R2", "no start on bit0 clear",
            {rd_log.size(), dones}, {r0, d0});

        // R9: explicit zero count
        r0 = rd_log.size(); b0 = beats; d0 = dones;
        cfg_write(8'h20, 0);
        cfg_write(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        chk(rd_log.size() == r0 && beats == b0 && dones == d0 + 1, "R9", "zero count",
            {rd_log.size(), beats, dones}, {r0, b0, d0 + 1});

        // R3: address wraps at the top of the address space
        rdy_mode = 2;
        r0 = rd_log.size();
        run_xfer(16'hFFE0, 3);
        chk(rd_log[r0] == 16'hFFE0 && rd_log[r0+1] == 16'hFFF0 && rd_log[r0+2] == 16'h0000,
            "R3", "address wrap", {rd_log[r0], rd_log[r0+1], rd_log[r0+2]},
            {16'hFFE0, 16'hFFF0, 16'h0000});

        // R6: long stall on a single beat
        rdy_mode = 3;
        cfg_write(8'h10, 32'h0440);
        cfg_write(8'h20, 1);
        cfg_write(8'h00, 32'h1);
        repeat (15) @(negedge clk);
        rdy_mode = 0;
        wait_done();

        // R7: immediate restart after completion
        d0 = dones;
        cfg_write(8'h00, 32'h1);
        wait_done();
        chk(dones == d0 + 1, "R7", "restart after done", dones, d0 + 1);

        chk(exp_rd.size() == 0 && exp_beat.size() == 0, "R5", "all expected traffic seen",
            {exp_rd.size(), exp_beat.size()}, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule